// File: doc/BRIEF.md
# Keyed Watchdog with Reset-Out

This block is a software watchdog for a small CPU core. Software starts it by writing a fixed two-byte key to a write-only service port, and it keeps it alive by writing the same key again. While running, it counts machine-cycle ticks. If software does not service it in time, the counter reaches its terminal value. The block then raises a one-cycle internal reset request. It also drives a reset-out pin high for a fixed number of oscillator clocks. Software cannot read or load the count, and it cannot stop the watchdog. Only a hardware reset or the watchdog's own overflow returns it to the disabled state.

Counting is gated by the core's low-power states. In power-down the count is frozen. After power-down ends, the count stays frozen as long as the active-low wake-up interrupt line is still held low. In idle, the count either continues or freezes and later resumes from the same value. A configuration bit chooses which. A second configuration bit suppresses the reset-out pin, so that only the internal request is given.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wdt_rst_o` and `rst_req_o` are 0 and the watchdog is disabled: ticks alone never produce a reset request.
- R2: A write of 0x1E followed directly by a write of 0xE1 (the next write on `wr_i`, any number of cycles later) enables the watchdog with a count of 0.
- R3: Repeating the 0x1E, 0xE1 sequence while enabled clears the count to 0, so the next overflow comes a full period after the 0xE1 write.
- R4: A write of any other value, or 0xE1 not directly preceded by 0x1E, aborts the key sequence and leaves the enable state and the count unchanged.
- R5: While enabled and not held, each cycle with `tick_i` high adds 1 to the CNT_W-bit count. The tick that brings the count to 2^CNT_W-1 (16383 by default) is an overflow. `rst_req_o` is high for exactly the one cycle after that tick.
- R6: On overflow with `no_rst_out_i` low, `wdt_rst_o` goes high in the same cycle as `rst_req_o` and stays high for exactly PULSE_LEN (default 98) clock cycles.
- R7: On overflow with `no_rst_out_i` high (sampled in the overflow cycle), `rst_req_o` still pulses and `wdt_rst_o` stays low.
- R8: Overflow disables the watchdog and clears its count and key state. No further request comes until the key sequence is written again.
- R9: In idle (`idle_i` high), the count keeps advancing when `idle_halt_i` is 0. When `idle_halt_i` is 1 it freezes and resumes from the same value once idle ends.
- R10: While `pdown_i` is high the count is frozen. After `pdown_i` falls, the count stays frozen while `wake_ni` is low and resumes on the first cycle `wake_ni` is high.
- R11: A key completion in the same cycle as the tick that would overflow wins. The count is cleared, and no request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| wr_i | input | 1 | Write strobe for the service port |
| wdata_i | input | 8 | Write data for the service port |
| idle_i | input | 1 | Core is in idle |
| pdown_i | input | 1 | Core is in power-down |
| wake_ni | input | 1 | Wake-up interrupt line, active low |
| no_rst_out_i | input | 1 | 1 suppresses the reset-out pin pulse |
| idle_halt_i | input | 1 | 1 freezes the count during idle |
| wdt_rst_o | output | 1 | Reset-out pin drive, high during the pulse |
| rst_req_o | output | 1 | One-cycle internal reset request on overflow |

## Verification
Two events can fall into one cycle here: a key completion and the tick that would carry the count to its terminal value. The bench drives the count to one below terminal and writes 0x1E. It then writes 0xE1 together with a tick. It judges the result by the absence of a request in that cycle and by a full period until the next overflow (R11). A key completion can also meet an idle freeze or a power-down hold. Random runs that mix key writes, holds and ticks are compared cycle by cycle against a bench reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_ARM_DEF  = 8'h1E;
  localparam logic [DATA_W-1:0] KEY_FIRE_DEF = 8'hE1;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdog_key_chk.sv
module wdog_key_chk
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_ARM  = KEY_ARM_DEF,
  parameter logic [DATA_W-1:0] KEY_FIRE = KEY_FIRE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              abort_i,
  output logic              key_ok_o
);
  key_state_e state_q;

  assign key_ok_o = wr_i && (state_q == KEY_ARMED) && (wdata_i == KEY_FIRE);

  // every write re-decides the state; only the arm byte leaves it armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= KEY_IDLE;
    else if (abort_i) state_q <= KEY_IDLE;
    else if (wr_i)    state_q <= (wdata_i == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
  end
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic idle_halt_i,
  input  logic pdown_i,
  input  logic wake_ni,
  output logic hold_o
);
  logic wake_hold_q;

  // remembers a power-down until the wake line has been released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wake_hold_q <= 1'b0;
    else if (pdown_i) wake_hold_q <= 1'b1;
    else if (wake_ni) wake_hold_q <= 1'b0;
  end

  assign hold_o = pdown_i | (idle_i & idle_halt_i) | (wake_hold_q & ~wake_ni);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clear_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}} - CNT_W'(1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = en_q && tick_i && !hold_i;
  assign ovf_o = step && !clear_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clear_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (ovf_o) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic quiet_i,
  output logic req_o,
  output logic pin_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= fire_i;
  end
  assign req_o = req_q;

  generate
    if (PULSE_LEN == 0) begin : g_no_pin
      assign pin_o = 1'b0;
    end else begin : g_pin
      localparam int unsigned PW = $clog2(PULSE_LEN + 1);
      logic [PW-1:0] left_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 left_q <= '0;
        else if (fire_i && !quiet_i) left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)       left_q <= left_q - PW'(1);
      end
      assign pin_o = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned       CNT_W     = 14,
  parameter int unsigned       PULSE_LEN = 98,
  parameter logic [DATA_W-1:0] KEY_ARM   = KEY_ARM_DEF,
  parameter logic [DATA_W-1:0] KEY_FIRE  = KEY_FIRE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_ni,
  input  logic              no_rst_out_i,
  input  logic              idle_halt_i,
  output logic              wdt_rst_o,
  output logic              rst_req_o
);
  logic             key_ok;
  logic             hold;
  logic             en;
  logic             ovf;
  logic [CNT_W-1:0] cnt;

  wdog_key_chk #(
    .KEY_ARM (KEY_ARM),
    .KEY_FIRE(KEY_FIRE)
  ) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .abort_i (ovf),
    .key_ok_o(key_ok)
  );

  wdog_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle_i),
    .idle_halt_i(idle_halt_i),
    .pdown_i    (pdown_i),
    .wake_ni    (wake_ni),
    .hold_o     (hold)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (hold),
    .clear_i(key_ok),
    .en_o   (en),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (ovf),
    .quiet_i(no_rst_out_i),
    .req_o  (rst_req_o),
    .pin_o  (wdt_rst_o)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_o,
  input logic             wdt_rst_o,
  input logic             no_rst_out_i,
  input logic             idle_i,
  input logic             idle_halt_i,
  input logic             pdown_i,
  input logic             en,
  input logic             key_ok,
  input logic [CNT_W-1:0] cnt
);
  // R5
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R1
  req_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(en));

  // R6
  pin_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !$past(no_rst_out_i)) |-> wdt_rst_o);

  // R6
  pin_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> rst_req_o);

  // R7
  pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && $past(no_rst_out_i)) |-> !wdt_rst_o);

  // R8
  ovf_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (!en && cnt == '0));

  // R3
  key_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |=> (en && cnt == '0));

  // R9
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && idle_halt_i && !key_ok) |=> $stable(cnt));

  // R10
  pdown_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_i && !key_ok) |=> $stable(cnt));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_req_o   (rst_req_o),
  .wdt_rst_o   (wdt_rst_o),
  .no_rst_out_i(no_rst_out_i),
  .idle_i      (idle_i),
  .idle_halt_i (idle_halt_i),
  .pdown_i     (pdown_i),
  .en          (en),
  .key_ok      (key_ok),
  .cnt         (cnt)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int PULSE_LEN  = 98;
  localparam int LIMIT      = (1 << CNT_W) - 1;
  localparam int WD_MAX     = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       idle = 1'b0, pdown = 1'b0, wake_n = 1'b1, norst = 1'b0, halt = 1'b0;
  logic       wdt_rst, rst_req;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyed_wdog #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wdata_i(wdata),
    .idle_i(idle), .pdown_i(pdown), .wake_ni(wake_n), .no_rst_out_i(norst),
    .idle_halt_i(halt), .wdt_rst_o(wdt_rst), .rst_req_o(rst_req)
  );

  // reference model built from the requirements
  bit m_en, m_armed, m_wake, m_req;
  int m_cnt, m_pulse;

  function automatic bit hold_f(bit wk);
    return pdown || (idle && halt) || (wk && !wake_n);
  endfunction

  function automatic bit keyok_f(bit armed);
    return wr && armed && (wdata == 8'hE1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_armed <= 0; m_wake <= 0; m_req <= 0; m_cnt <= 0; m_pulse <= 0;
    end else begin
      bit kok, stp, ovf;
      kok = keyok_f(m_armed);
      stp = m_en && tick && !hold_f(m_wake);
      ovf = stp && !kok && (m_cnt == LIMIT - 1);
      m_req <= ovf;
      m_pulse <= (ovf && !norst) ? PULSE_LEN : (m_pulse > 0 ? m_pulse - 1 : 0);
      m_wake <= pdown ? 1'b1 : (wake_n ? 1'b0 : m_wake);
      if (ovf) m_armed <= 1'b0;
      else if (wr) m_armed <= (wdata == 8'h1E);
      if (kok) begin m_en <= 1'b1; m_cnt <= 0; end
      else if (ovf) begin m_en <= 1'b0; m_cnt <= 0; end
      else if (stp) m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rst_req == m_req, "R5 rst_req model", int'(rst_req), int'(m_req));
      check(wdt_rst == (m_pulse != 0), "R6 wdt_rst model", int'(wdt_rst), int'(m_pulse != 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WD_MAX);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(bit t, bit w, logic [7:0] d);
    tick = t; wr = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0;
  endtask

  task automatic key();
    step(0, 1, 8'h1E);
    step(0, 1, 8'hE1);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 8'h00);
  endtask

  task automatic run_to_req(output int n);
    n = 0;
    while (n < 3000) begin
      step(1, 0, 8'h00);
      n++;
      if (rst_req) break;
    end
  endtask

  task automatic pin_len(output int k);
    k = 0;
    while (wdt_rst && k < 300) begin
      k++;
      step(0, 0, 8'h00);
    end
  endtask

  initial begin
    int n, k, seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_req == 0 && wdt_rst == 0, "R1 outputs after reset", int'(rst_req) + int'(wdt_rst), 0);
    rst_n = 1'b1;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < LIMIT + 40; i++) begin step(1, 0, 0); seen += int'(rst_req); end
    check(seen == 0, "R1 disabled after reset", seen, 0);

    // R4 lone fire byte and broken sequence
    step(0, 1, 8'hE1); ticks(20);
    step(0, 1, 8'h1E); step(0, 1, 8'h55); step(0, 1, 8'hE1);
    seen = 0;
    for (int i = 0; i < LIMIT + 40; i++) begin step(1, 0, 0); seen += int'(rst_req); end
    check(seen == 0, "R4 bad key ignored", seen, 0);

    // R2 R5 enable and overflow timing, R6 pulse length, R8 stays off
    key(); run_to_req(n);
    check(n == LIMIT, "R2 R5 ticks to overflow", n, LIMIT);
    pin_len(k);
    check(k == PULSE_LEN, "R6 pulse length", k, PULSE_LEN);
    seen = 0;
    for (int i = 0; i < 2 * LIMIT; i++) begin step(1, 0, 0); seen += int'(rst_req); end
    check(seen == 0, "R8 disabled after overflow", seen, 0);

    // R4 wrong byte while enabled does not touch count; R3 key clears count
    key(); ticks(100); step(0, 1, 8'h00); step(0, 1, 8'hE1); run_to_req(n);
    check(n == LIMIT - 100, "R4 count untouched by bad write", n, LIMIT - 100);
    ticks(PULSE_LEN + 5);
    key(); ticks(200); key(); run_to_req(n);
    check(n == LIMIT, "R3 service clears count", n, LIMIT);
    ticks(PULSE_LEN + 5);

    // R7 suppressed pin
    norst = 1'b1;
    key(); run_to_req(n);
    check(n == LIMIT && wdt_rst == 0, "R7 request without pin", int'(wdt_rst), 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin step(0, 0, 0); seen += int'(wdt_rst); end
    check(seen == 0, "R7 pin stays low", seen, 0);
    norst = 1'b0;

    // R9 idle with halt=1 freezes, halt=0 counts
    key(); ticks(100); idle = 1; halt = 1; ticks(50); idle = 0; run_to_req(n);
    check(n == LIMIT - 100, "R9 idle freeze resumes", n, LIMIT - 100);
    ticks(PULSE_LEN + 5);
    key(); idle = 1; halt = 0; ticks(100); run_to_req(n); idle = 0;
    check(n == LIMIT - 100, "R9 idle counting", n, LIMIT - 100);
    ticks(PULSE_LEN + 5);

    // R10 power-down then wake line held low
    key(); ticks(100); pdown = 1; ticks(40); pdown = 0; wake_n = 0; ticks(20);
    wake_n = 1; run_to_req(n);
    check(n == LIMIT - 100, "R10 power-down and wake hold", n, LIMIT - 100);
    ticks(PULSE_LEN + 5);

    // R11 key completion on the overflowing tick
    key(); ticks(LIMIT - 1); step(0, 1, 8'h1E); step(1, 1, 8'hE1);
    check(rst_req == 0, "R11 no request on collision", int'(rst_req), 0);
    run_to_req(n);
    check(n == LIMIT, "R11 full period after collision", n, LIMIT);
    ticks(PULSE_LEN + 5);

    // random mix against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      if (r < 3) idle = ~idle;
      if (r == 4) halt = ~halt;
      if (r == 5) pdown = ~pdown;
      if (r == 6 || r == 7) wake_n = ~wake_n;
      if (r == 8) norst = ~norst;
      d = ($urandom_range(0, 2) == 0) ? 8'($urandom) : (($urandom_range(0, 1) == 0) ? 8'h1E : 8'hE1);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0, d);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule